// File: doc/BRIEF.md
# Frame interrupt controller

This block turns display timing events into a single frame-level interrupt request. A timing generator elsewhere supplies one-cycle pulses for four points of each frame: back porch, vsync, active start and front porch. Two independent event sources can each be pointed at any one of these points, or switched off. When an enabled source sees its chosen event, a sticky pending bit is set.

Software programs a control register and a pending register through a simple single-cycle write port and a combinational read port. The interrupt line is raised only when the pending bit is set and both the global enable and the frame enable are on. The pending bit is cleared by writing one to it. The active-low reset is applied asynchronously and released through a two-stage synchroniser, so register writes take effect from the third rising edge after reset is released.

Top module: `frame_irq_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the pending register (address 1) both read zero and irq is low.
- R2: A write to address 0 stores the control byte, which reads back unchanged at address 0: bit 0 global enable, bit 1 frame enable, bit 2 source A enable, bits 4:3 source A event code, bit 5 source B enable, bits 7:6 source B event code.
- R3: A control write whose bit 0 (global enable) is 0 stores bit 1 (frame enable) as 0, whatever value was written there, so turning the interrupt off clears both enables.
- R4: Event code c selects bit c of `tim_evt`: 0 back porch, 1 vsync, 2 active start, 3 front porch. An enabled source whose selected bit is high at a rising edge sets the pending bit after that edge; pulses on other bits do not.
- R5: A source whose enable bit is 0 selects no event and never sets the pending bit.
- R6: The pending bit reads as bit 0 of address 1. Writing that bit as 1 clears it after the edge; writing it as 0 leaves it unchanged.
- R7: When a selected event and a write-one-to-clear occur at the same edge, the pending bit ends up set.
- R8: The pending bit sets on a selected event even while the global or frame enable is 0.
- R9: irq is high exactly when the pending bit, the global enable and the frame enable are all 1, following the registers after each edge with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 1 | Write address: 0 control, 1 pending |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 1 | Read address: 0 control, 1 pending |
| reg_rdata | output | 8 | Read data for reg_raddr, combinational |
| tim_evt | input | 4 | Timing event pulses, bit index equals event code |
| irq | output | 1 | Frame interrupt request |

## Verification
The assertions take for granted that the event pulses and register strobes are synchronous to `clk` and settled at each rising edge, and that no write is expected to land during the two synchroniser cycles after reset release. The stimulus changes every input only at the falling edge, holds off writes and events until the internal reset has been released, and keeps event pulses sparse enough in the random phase that both the set and the clear paths of the pending bit are taken often, including the collision of the two.

// File: rtl/fic_pkg.sv
package fic_pkg;

  // register addresses of the write and read ports
  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_PEND = 1'b1
  } fic_addr_e;

  // fixed bit positions in the control register; source fields follow
  localparam int GEN_BIT  = 0;
  localparam int FRM_BIT  = 1;
  localparam int SRC_BASE = 2;

endpackage

// File: rtl/fic_rst_sync.sv
module fic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fic_ctrl_reg.sv
module fic_ctrl_reg
  import fic_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_val,
  output logic [CTRL_W-1:0] ctrl_q
);

  logic [CTRL_W-1:0] ctrl_d;

  // next state: a write that drops the global enable also drops frame enable
  always_comb begin
    ctrl_d = wr_val;
    if (!wr_val[GEN_BIT]) begin
      ctrl_d[FRM_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // R3: turning the interrupt off leaves frame enable clear
  a_r3_off_clears_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_val[GEN_BIT]) |=> !ctrl_q[FRM_BIT]);

  // R2: the control register only changes on a write
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/fic_src_match.sv
module fic_src_match #(
  parameter int NUM_SRC = 2,
  parameter int NUM_EVT = 4,
  localparam int SEL_W   = $clog2(NUM_EVT),
  localparam int FIELD_W = 1 + SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC*FIELD_W-1:0] src_cfg,
  input  logic [NUM_EVT-1:0]         tim_evt,
  output logic                       hit
);

  logic [NUM_SRC-1:0] hit_vec;

  // one comparator per source: enable bit, then event code above it
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    logic             src_en;
    logic [SEL_W-1:0] src_code;

    assign src_en   = src_cfg[k*FIELD_W];
    assign src_code = src_cfg[k*FIELD_W+1 +: SEL_W];

    always_comb begin
      hit_vec[k] = 1'b0;
      if (src_en && (int'(src_code) < NUM_EVT)) begin
        hit_vec[k] = tim_evt[src_code];
      end
    end

    // R5: a disabled source contributes nothing
    a_r5_disabled_source_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !src_en |-> !hit_vec[k]);
  end

  assign hit = |hit_vec;

  // R4: no hit without some timing event present
  a_r4_hit_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (tim_evt != '0));

endmodule

// File: rtl/fic_pending.sv
module fic_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_q
);

  logic pend_d;
  logic pend_ld;

  // set has priority over write-one-to-clear
  always_comb begin
    pend_ld = set_i | clr_i;
    pend_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_ld) begin
      pend_q <= pend_d;
    end
  end

  // R7, R8: an event always leaves the bit set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);

  // R6: a clear without an event empties the bit
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_q);

  // R6: with neither set nor clear the bit holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(pend_q));

endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl
  import fic_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int NUM_EVT = 4,
  parameter int DATA_W  = 8,
  localparam int SEL_W   = $clog2(NUM_EVT),
  localparam int FIELD_W = 1 + SEL_W,
  localparam int CTRL_W  = SRC_BASE + NUM_SRC*FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_EVT-1:0] tim_evt,
  output logic              irq
);

  logic              rst_n_int;
  logic              ctrl_we;
  logic              pend_clr;
  logic              evt_hit;
  logic              pend_q;
  logic [CTRL_W-1:0] ctrl_q;

  fic_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign ctrl_we  = reg_we && (reg_waddr == ADDR_CTRL);
  assign pend_clr = reg_we && (reg_waddr == ADDR_PEND) && reg_wdata[0];

  fic_ctrl_reg #(.CTRL_W(CTRL_W)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (ctrl_we),
    .wr_val (reg_wdata[CTRL_W-1:0]),
    .ctrl_q (ctrl_q)
  );

  fic_src_match #(.NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT)) i_match (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .src_cfg (ctrl_q[CTRL_W-1:SRC_BASE]),
    .tim_evt (tim_evt),
    .hit     (evt_hit)
  );

  fic_pending i_pend (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .set_i  (evt_hit),
    .clr_i  (pend_clr),
    .pend_q (pend_q)
  );

  // read mux, zero-extended to the data width
  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == ADDR_PEND) begin
      reg_rdata[0] = pend_q;
    end else begin
      reg_rdata[CTRL_W-1:0] = ctrl_q;
    end
  end

  assign irq = pend_q & ctrl_q[GEN_BIT] & ctrl_q[FRM_BIT];

  // R9: a clear with no event drops the request after the edge
  a_r9_irq_drops_on_clear: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pend_clr && !evt_hit) |=> !irq);

  // R3, R9: switching the interrupt off silences irq after the edge
  a_r9_irq_off_after_disable: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ctrl_we && !reg_wdata[GEN_BIT]) |=> !irq);

endmodule

// File: tb/test_frame_irq_ctrl.sv
module test_frame_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic       reg_waddr;
  logic [7:0] reg_wdata;
  logic       reg_raddr;
  logic [7:0] reg_rdata;
  logic [3:0] tim_evt;
  logic       irq;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  logic [7:0] m_ctrl;
  logic       m_pend;

  always #10 clk = ~clk;

  frame_irq_ctrl i_frame_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .reg_wdata (reg_wdata),
    .reg_raddr (reg_raddr),
    .reg_rdata (reg_rdata),
    .tim_evt   (tim_evt),
    .irq       (irq)
  );

  // R4/R5: event hit from the control byte layout
  function automatic logic src_set(logic [7:0] c, logic [3:0] e);
    for (int k = 0; k < 2; k++) begin
      if (c[2+3*k] && e[c[3+3*k +: 2]]) return 1'b1;
    end
    return 1'b0;
  endfunction

  // R3: stored control value
  function automatic logic [7:0] ctrl_next(logic [7:0] w);
    logic [7:0] v = w;
    if (!w[0]) v[1] = 1'b0;
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic we, logic wa, logic [7:0] wd,
                     logic [3:0] ev, logic ra);
    logic set, clr;
    @(negedge clk);
    reg_we = we; reg_waddr = wa; reg_wdata = wd; tim_evt = ev; reg_raddr = ra;
    set = src_set(m_ctrl, ev);
    clr = we && wa && wd[0];
    @(posedge clk);
    #1;
    if (set) m_pend = 1'b1;
    else if (clr) m_pend = 1'b0;
    if (we && !wa) m_ctrl = ctrl_next(wd);
    chk({tag, " irq"}, irq, m_pend & m_ctrl[0] & m_ctrl[1]);
    chk({tag, " rdata"}, reg_rdata, ra ? {7'b0, m_pend} : m_ctrl);
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; reg_we = 0; reg_waddr = 0; reg_wdata = 0;
    tim_evt = 0; reg_raddr = 0;
    m_ctrl = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle through synchroniser release, both registers read zero
    for (int i = 0; i < 4; i++) cyc("R1", 0, 0, 8'h00, 4'h0, i[0]);
    chk("R1 irq low", irq, 0);

    // R2: full byte readback
    cyc("R2", 1, 0, 8'hE7, 4'h0, 0);
    chk("R2 readback", reg_rdata, 8'hE7);
    // R3: frame enable without global enable is dropped
    cyc("R3", 1, 0, 8'h02, 4'h0, 0);
    chk("R3 frame cleared", reg_rdata, 8'h00);
    cyc("R3", 1, 0, 8'hE7, 4'h0, 0);
    cyc("R3", 1, 0, 8'hE6, 4'h0, 0);
    chk("R3 off clears both", reg_rdata, 8'hE4);

    // R8: source A on vsync, interrupt disabled
    cyc("R8", 1, 0, 8'h0C, 4'h0, 1);
    cyc("R8", 0, 0, 8'h00, 4'h2, 1);
    chk("R8 pending set", reg_rdata, 8'h01);
    chk("R8 irq held low", irq, 0);
    // R9: enabling exposes pending
    cyc("R9", 1, 0, 8'h0F, 4'h0, 1);
    chk("R9 irq high", irq, 1);
    // R6: write zero keeps, write one clears
    cyc("R6", 1, 1, 8'hFE, 4'h0, 1);
    chk("R6 zero keeps", reg_rdata, 8'h01);
    cyc("R6", 1, 1, 8'h01, 4'h0, 1);
    chk("R6 one clears", reg_rdata, 8'h00);
    chk("R9 irq low after clear", irq, 0);
    // R7: collision of event and clear
    cyc("R7", 1, 1, 8'h01, 4'h2, 1);
    chk("R7 set wins", reg_rdata, 8'h01);
    chk("R7 irq", irq, 1);

    // R5: both sources disabled, every event pulsing
    cyc("R5", 1, 1, 8'h01, 4'h0, 1);
    cyc("R5", 1, 0, 8'h4B, 4'h0, 1);
    cyc("R5", 0, 0, 8'h00, 4'hF, 1);
    chk("R5 none ignored", reg_rdata, 8'h00);
    chk("R5 irq low", irq, 0);

    // R4: each code on source B, wrong events then the right one
    for (int c = 0; c < 4; c++) begin
      cyc("R4", 1, 0, 8'h23 | 8'(c << 6), 4'h0, 1);
      cyc("R4", 0, 0, 8'h00, ~(4'b1 << c), 1);
      chk("R4 other events ignored", reg_rdata, 8'h00);
      cyc("R4", 0, 0, 8'h00, 4'b1 << c, 1);
      chk("R4 code selects event", reg_rdata, 8'h01);
      cyc("R4", 1, 1, 8'h01, 4'h0, 1);
    end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic we, wa, ra;
      logic [7:0] wd;
      logic [3:0] ev;
      we = ($urandom_range(0, 3) == 0);
      wa = 1'($urandom);
      wd = 8'($urandom);
      ev = ($urandom_range(0, 2) == 0) ? 4'b1 << $urandom_range(0, 3) : 4'h0;
      if ($urandom_range(0, 15) == 0) ev = 4'($urandom);
      ra = 1'($urandom);
      cyc(ra ? "R6 random" : "R2 random", we, wa, wd, ev, ra);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule